// File: doc/BRIEF.md
# Learned State-Transition Anomaly Monitor

The monitor samples a small vector of interface signals on every clock and treats each distinct sampled value as a state. In learn mode it marks every state it sees in a vertex bitmap, and every change from one state to a different state in an adjacency bitmap. Learning only ever sets bits, so several known-good runs made without a clear in between build one merged diagram of allowed behaviour.

In check mode the monitor walks the live state sequence and looks up each state and each transition in the learned diagram. On the first state or transition that was never learned it raises a sticky flag and records four things: whether the miss was a vertex or an edge, the previous state, the current state and the cycle number. It then stops checking until reset or a table clear. A clear request walks through the tables one row per cycle and shows busy while it does so.

The controller has three named states:
- RUN: sample, learn and check.
- HALT: hold the captured violation.
- CLEAR: zero one table row per cycle.

The transitions are:
- RUN to HALT on a violation.
- RUN to CLEAR and HALT to CLEAR on a clear request.
- CLEAR to RUN after the last row is zeroed.

Top module: `anomaly_monitor`

## Requirements
- R1: While reset is held and after its release, viol_flag, viol_is_edge, viol_prev, viol_curr, viol_cycle and busy are all 0, and both tables are empty.
- R2: The state sampled in a cycle is the whole sig_in value. Two values that differ in any bit are distinct states, and viol_curr reports the full value.
- R3: With learn_mode=1, each sample marks its state as known. When a previous sample exists and differs from the current one, the pair (previous, current) is marked as a known edge. Learn mode never raises viol_flag.
- R4: Learning only adds entries. Learn runs separated by check runs, with no clear in between, accumulate the union of all vertices and edges. A check run over any mix of those edges raises no flag.
- R5: With learn_mode=0, a sample whose state is not known raises viol_flag with viol_is_edge=0 in the cycle after that sample. viol_curr is that state.
- R6: With learn_mode=0, a sample whose state is known but whose change from a different previous state is not a known edge raises viol_flag with viol_is_edge=1. viol_prev and viol_curr give the pair. A sample equal to the previous one is never checked as an edge.
- R7: When a sample is both an unknown state and an unknown edge, exactly one violation is reported, with viol_is_edge=0.
- R8: The first sample after reset or after a clear has no predecessor. Only its vertex is checked, and if it is reported, viol_prev is 0.
- R9: Once viol_flag is 1, it and the captured details stay unchanged, whatever sig_in and learn_mode do, until reset or a clear. No further learning or checking happens.
- R10: A clr_req seen outside a clear sets busy in the next cycle. Busy then stays high for exactly 2^SIG_W cycles. The sample in the request cycle and all samples while busy are ignored. After the clear both tables are empty and all violation outputs are 0.
- R11: A CNT_W-bit counter reads 0 in the first cycle after reset release and advances by one every cycle. It is not restarted by a clear. viol_cycle holds its value from the cycle of the violating sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| learn_mode | input | 1 | 1 = learn, 0 = check |
| clr_req | input | 1 | Request to empty both tables |
| sig_in | input | SIG_W | Monitored signal vector |
| busy | output | 1 | Table clear in progress |
| viol_flag | output | 1 | Sticky violation flag |
| viol_is_edge | output | 1 | 0 = new vertex, 1 = new edge |
| viol_prev | output | SIG_W | State before the violating sample |
| viol_curr | output | SIG_W | Violating state |
| viol_cycle | output | CNT_W | Cycle count of the violating sample |

## Verification
A vertex miss and an edge miss can fall in the same sample when a check run steps from a known state into a never-seen state. The bench provokes this by learning only the states 0 and 1, then stepping from 1 to 7 in check mode. It judges the result by requiring a single flag with kind 0 and the pair (1, 7). A second coincidence, a clear request arriving in the same cycle as a violating sample, is provoked separately and must leave the flag at 0.

// File: rtl/mon_pkg.sv
package mon_pkg;
    typedef enum logic [1:0] {
        MS_RUN   = 2'd0,
        MS_CLEAR = 2'd1,
        MS_HALT  = 2'd2
    } mon_state_e;

    typedef enum logic {
        VK_VERTEX = 1'b0,
        VK_EDGE   = 1'b1
    } viol_kind_e;
endpackage

// File: rtl/mon_cycle_ctr.sv
module mon_cycle_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/mon_graph_store.sv
module mon_graph_store #(
    parameter int SIG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [SIG_W-1:0] clr_row,
    input  logic             learn_v,
    input  logic             learn_e,
    input  logic [SIG_W-1:0] cur,
    input  logic [SIG_W-1:0] prev,
    output logic             v_known,
    output logic             e_known
);
    localparam int NUM_ST = 1 << SIG_W;

    logic              vtab [NUM_ST];
    logic [NUM_ST-1:0] etab [NUM_ST];

    for (genvar r = 0; r < NUM_ST; r++) begin : g_row
        localparam logic [SIG_W-1:0] ROW = SIG_W'(r);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vtab[r] <= 1'b0;
                etab[r] <= '0;
            end else if (clr_en && (clr_row == ROW)) begin
                vtab[r] <= 1'b0;
                etab[r] <= '0;
            end else begin
                if (learn_v && (cur == ROW)) begin
                    vtab[r] <= 1'b1;
                end
                if (learn_e && (prev == ROW)) begin
                    etab[r][cur] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        v_known = vtab[cur];
        e_known = etab[prev][cur];
    end
endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
    import mon_pkg::*;
#(
    parameter int SIG_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             learn_mode,
    input  logic             clr_req,
    input  logic [SIG_W-1:0] sig_in,
    input  logic [CNT_W-1:0] cyc,
    input  logic             v_known,
    input  logic             e_known,
    output logic             clr_en,
    output logic [SIG_W-1:0] clr_row,
    output logic             learn_v,
    output logic             learn_e,
    output logic [SIG_W-1:0] prev_q,
    output logic             busy,
    output logic             viol_flag,
    output logic             viol_is_edge,
    output logic [SIG_W-1:0] viol_prev,
    output logic [SIG_W-1:0] viol_curr,
    output logic [CNT_W-1:0] viol_cycle
);
    localparam logic [SIG_W-1:0] LAST_ROW = '1;

    mon_state_e       state_q, state_d;
    logic [SIG_W-1:0] idx_q;
    logic             have_prev_q;
    logic             sample_ok, has_edge, new_v, new_e, start_clr;
    viol_kind_e       kind;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_RUN: begin
                if (clr_req) begin
                    state_d = MS_CLEAR;
                end else if (new_v || new_e) begin
                    state_d = MS_HALT;
                end
            end
            MS_HALT: begin
                if (clr_req) begin
                    state_d = MS_CLEAR;
                end
            end
            MS_CLEAR: begin
                if (idx_q == LAST_ROW) begin
                    state_d = MS_RUN;
                end
            end
            default: state_d = MS_RUN;
        endcase
    end

    // outputs and strobes
    always_comb begin
        start_clr = clr_req && (state_q != MS_CLEAR);
        sample_ok = (state_q == MS_RUN) && !clr_req;
        has_edge  = have_prev_q && (prev_q != sig_in);
        new_v     = sample_ok && !learn_mode && !v_known;
        new_e     = sample_ok && !learn_mode && v_known && has_edge && !e_known;
        learn_v   = sample_ok && learn_mode;
        learn_e   = learn_v && has_edge;
        clr_en    = (state_q == MS_CLEAR);
        clr_row   = idx_q;
        busy      = (state_q == MS_CLEAR);
        kind      = new_v ? VK_VERTEX : VK_EDGE;
    end

    // clear row walker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q == MS_CLEAR) begin
            idx_q <= idx_q + 1'b1;
        end else begin
            idx_q <= '0;
        end
    end

    // predecessor tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (start_clr) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (sample_ok) begin
            prev_q      <= sig_in;
            have_prev_q <= 1'b1;
        end
    end

    // violation capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_flag    <= 1'b0;
            viol_is_edge <= 1'b0;
            viol_prev    <= '0;
            viol_curr    <= '0;
            viol_cycle   <= '0;
        end else if (start_clr) begin
            viol_flag    <= 1'b0;
            viol_is_edge <= 1'b0;
            viol_prev    <= '0;
            viol_curr    <= '0;
            viol_cycle   <= '0;
        end else if (new_v || new_e) begin
            viol_flag    <= 1'b1;
            viol_is_edge <= (kind == VK_EDGE);
            viol_prev    <= prev_q;
            viol_curr    <= sig_in;
            viol_cycle   <= cyc;
        end
    end
endmodule

// File: rtl/anomaly_monitor.sv
module anomaly_monitor #(
    parameter int SIG_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             learn_mode,
    input  logic             clr_req,
    input  logic [SIG_W-1:0] sig_in,
    output logic             busy,
    output logic             viol_flag,
    output logic             viol_is_edge,
    output logic [SIG_W-1:0] viol_prev,
    output logic [SIG_W-1:0] viol_curr,
    output logic [CNT_W-1:0] viol_cycle
);
    logic [CNT_W-1:0] cyc_cnt;
    logic             clr_en, learn_v, learn_e, v_known, e_known;
    logic [SIG_W-1:0] clr_row, prev_q;

    mon_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cyc_cnt)
    );

    mon_graph_store #(.SIG_W(SIG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_row (clr_row),
        .learn_v (learn_v),
        .learn_e (learn_e),
        .cur     (sig_in),
        .prev    (prev_q),
        .v_known (v_known),
        .e_known (e_known)
    );

    mon_ctrl #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .learn_mode   (learn_mode),
        .clr_req      (clr_req),
        .sig_in       (sig_in),
        .cyc          (cyc_cnt),
        .v_known      (v_known),
        .e_known      (e_known),
        .clr_en       (clr_en),
        .clr_row      (clr_row),
        .learn_v      (learn_v),
        .learn_e      (learn_e),
        .prev_q       (prev_q),
        .busy         (busy),
        .viol_flag    (viol_flag),
        .viol_is_edge (viol_is_edge),
        .viol_prev    (viol_prev),
        .viol_curr    (viol_curr),
        .viol_cycle   (viol_cycle)
    );
endmodule

// File: rtl/anomaly_monitor_chk.sv
module anomaly_monitor_chk #(
    parameter int SIG_W = 4,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             learn_mode,
    input logic             clr_req,
    input logic             busy,
    input logic             viol_flag,
    input logic             viol_is_edge,
    input logic [SIG_W-1:0] viol_prev,
    input logic [SIG_W-1:0] viol_curr,
    input logic [CNT_W-1:0] viol_cycle,
    input logic [CNT_W-1:0] cyc
);
    localparam int NUM_ST = 1 << SIG_W;

    int   busy_len;
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= 0;
            armed    <= 1'b0;
        end else begin
            armed    <= 1'b1;
            busy_len <= busy ? busy_len + 1 : 0;
        end
    end

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(viol_flag) |-> busy);

    // R9
    details_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && $past(viol_flag)) |->
            $stable({viol_is_edge, viol_prev, viol_curr, viol_cycle}));

    // R10
    clear_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < NUM_ST));

    // R10
    clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(clr_req));

    // R10
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !viol_flag);

    // R6
    edge_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && viol_is_edge) |-> (viol_prev != viol_curr));

    // R3
    learn_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_flag) |-> !$past(learn_mode));

    // R11
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cyc == $past(cyc) + 1'b1));
endmodule

bind anomaly_monitor anomaly_monitor_chk #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .learn_mode   (learn_mode),
    .clr_req      (clr_req),
    .busy         (busy),
    .viol_flag    (viol_flag),
    .viol_is_edge (viol_is_edge),
    .viol_prev    (viol_prev),
    .viol_curr    (viol_curr),
    .viol_cycle   (viol_cycle),
    .cyc          (cyc_cnt)
);

// File: tb/tb_anomaly_monitor.sv
`timescale 1ns/1ps
module tb_anomaly_monitor;
    localparam int SIG_W  = 4;
    localparam int CNT_W  = 32;
    localparam int NUM_ST = 1 << SIG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             learn_mode = 1'b1;
    logic             clr_req = 1'b0;
    logic [SIG_W-1:0] sig_in = '0;
    logic             busy, viol_flag, viol_is_edge;
    logic [SIG_W-1:0] viol_prev, viol_curr;
    logic [CNT_W-1:0] viol_cycle;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    anomaly_monitor #(.SIG_W(SIG_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .learn_mode(learn_mode), .clr_req(clr_req),
        .sig_in(sig_in), .busy(busy), .viol_flag(viol_flag),
        .viol_is_edge(viol_is_edge), .viol_prev(viol_prev),
        .viol_curr(viol_curr), .viol_cycle(viol_cycle)
    );

    // behavioural reference
    bit      vseen [NUM_ST];
    bit      eseen [NUM_ST][NUM_ST];
    bit      m_busy, m_halt, m_flag, m_edge, m_havep;
    int      m_left, m_prev, m_curr, m_vprev;
    longint  m_cyc, m_vcyc;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < NUM_ST; i++) begin
            vseen[i] = 1'b0;
            for (int j = 0; j < NUM_ST; j++) eseen[i][j] = 1'b0;
        end
        m_flag = 0; m_edge = 0; m_vprev = 0; m_curr = 0; m_vcyc = 0;
        m_havep = 0; m_prev = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            wipe();
            m_busy = 0; m_halt = 0; m_left = 0; m_cyc = 0;
        end else begin
            int s;
            s = int'(sig_in);
            if (m_busy) begin
                m_left--;
                if (m_left == 0) m_busy = 0;
            end else if (clr_req) begin
                wipe();
                m_busy = 1; m_halt = 0; m_left = NUM_ST;
            end else if (!m_halt) begin
                if (learn_mode) begin
                    vseen[s] = 1'b1;
                    if (m_havep && m_prev != s) eseen[m_prev][s] = 1'b1;
                end else if (!vseen[s] || (m_havep && m_prev != s && !eseen[m_prev][s])) begin
                    m_flag = 1; m_halt = 1;
                    m_edge = vseen[s];
                    m_vprev = m_prev; m_curr = s; m_vcyc = m_cyc;
                end
                m_prev = s; m_havep = 1;
            end
            m_cyc = (m_cyc + 1) % (64'd1 << CNT_W);
        end
        #3;
        if (!done) begin
            chk("R10 busy", busy, m_busy);
            chk("R5 viol_flag", viol_flag, m_flag);
            chk("R6 viol_is_edge", viol_is_edge, m_edge);
            chk("R8 viol_prev", viol_prev, m_vprev);
            chk("R2 viol_curr", viol_curr, m_curr);
            chk("R11 viol_cycle", viol_cycle, m_vcyc);
        end
    end

    // drive at a negedge, return at the next negedge
    task automatic step(input bit l, input int s);
        learn_mode = l; sig_in = SIG_W'(s); clr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clear(input bit with_sample, input int s);
        clr_req = 1'b1; learn_mode = !with_sample; sig_in = SIG_W'(s);
        @(negedge clk);
        clr_req = 1'b0;
        chk("R10 busy after request", busy, 1);
        for (int k = 0; k < NUM_ST; k++) begin
            sig_in = SIG_W'(k ^ 5); learn_mode = k[0];
            @(negedge clk);
        end
        chk("R10 busy ends", busy, 0);
        chk("R10 flag cleared", viol_flag, 0);
    endtask

    task automatic expect_viol(input string tag, input bit e, input int p, input int c);
        chk({tag, " flag"}, viol_flag, 1);
        chk({tag, " kind"}, viol_is_edge, e);
        chk({tag, " prev"}, viol_prev, p);
        chk({tag, " curr"}, viol_curr, c);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 flag in reset", viol_flag, 0);
        chk("R1 busy in reset", busy, 0);
        chk("R1 cycle in reset", viol_cycle, 0);
        rst_n = 1'b1;

        // R8 first sample has no predecessor, empty table -> new vertex at cycle 0
        step(0, 9);
        expect_viol("R8 first sample", 0, 0, 9);
        chk("R11 cycle of first sample", viol_cycle, 0);

        // R9 halted: inputs ignored
        step(1, 3); step(0, 12); step(0, 9);
        expect_viol("R9 sticky", 0, 0, 9);

        do_clear(0, 0);

        // R3 learn run A with a repeat
        step(1, 0); step(1, 1); step(1, 2); step(1, 3); step(1, 3); step(1, 1); step(1, 0);
        chk("R3 learn raises nothing", viol_flag, 0);
        step(0, 0); step(0, 1); step(0, 2); step(0, 3); step(0, 3); step(0, 1); step(0, 0);
        chk("R3 learned path clean", viol_flag, 0);
        chk("R6 repeat is no edge", viol_flag, 0);

        // R4 learn run B merges
        step(1, 5); step(1, 2);
        step(0, 2); step(0, 3); step(0, 1); step(0, 0); step(0, 5); step(0, 2); step(0, 3);
        chk("R4 merged diagram clean", viol_flag, 0);

        // R6 new edge between known vertices
        step(0, 0);
        expect_viol("R6 new edge", 1, 3, 0);
        step(0, 1);
        expect_viol("R9 hold after edge", 1, 3, 0);

        do_clear(0, 0);
        chk("R10 tables emptied busy low", busy, 0);

        // R7 vertex and edge miss in one sample
        step(1, 0); step(1, 1);
        step(0, 1); step(0, 7);
        expect_viol("R7 vertex before edge", 0, 1, 7);

        // R2 single-bit difference is a distinct state
        do_clear(0, 0);
        step(1, 3); step(0, 3); step(0, 7);
        expect_viol("R2 distinct state", 0, 3, 7);

        // R10 clear request together with a violating sample
        do_clear(0, 0);
        step(1, 4);
        do_clear(1, 8);
        chk("R10 coincident sample ignored", viol_flag, 0);
        step(0, 4);
        expect_viol("R10 tables empty after clear", 0, 0, 4);

        // R11 counter restarts on reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 flag after reset", viol_flag, 0);
        rst_n = 1'b1;
        step(1, 1); step(1, 1); step(0, 6);
        expect_viol("R11 after reset", 0, 1, 6);
        chk("R11 cycle count restarted", viol_cycle, 2);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule